// File: doc/BRIEF.md
# Virtual-Zero Switching Sequence Generator

This block sits in the modulation path of a multilevel voltage-source inverter. It comes after the stage that finds the small triangle holding the tip of the reference vector. It receives the three vertex switching states of that triangle, each a three-phase word of levels 0..N_LEVELS-1, together with a sampling-interval parity bit. It returns the four-state switching sequence for the interval. One vertex acts as a virtual zero vector. Two of its redundant states open and close the sequence, and the other two vertices fill the middle, so that every transition moves one phase by one level.

Any vertex may be given in any of its redundant forms. The block shifts each vertex up to its highest redundant form. It ranks the vertices by their offset from the true origin and tries them in rank order as the virtual zero. It keeps the first one for which a single-step ordering exists. The parity bit mirrors the sequence so that successive intervals run forward and backward. All results appear in registers one clock after a valid input.

Top module: `vzs_seq_gen`

## Requirements
- R1: A state word packs phase a in bits [3*LW-1:2*LW], phase b in [2*LW-1:LW] and phase c in [LW-1:0], with LW = clog2(N_LEVELS). The redundant forms of a vertex are obtained by adding one common k to all phases while every level stays in 0..N_LEVELS-1. The "last" form uses the largest such k, so its highest phase equals N_LEVELS-1.
- R2: The offset cost of a vertex is |2a-b-c|*1024 + |b-c|*1774. Vertices are ranked by cost, ascending, and a tie goes to the lower vertex index.
- R3: Only a vertex with at least two redundant forms (max minus min level below N_LEVELS-1) can be the virtual zero. Its second-last form starts the forward sequence and its last form ends it.
- R4: Each of the other two vertices appears in the sequence only in its last form, whatever form it was given in.
- R5: In every valid sequence, adjacent states differ in exactly one phase, and that phase differs by exactly one level.
- R6: The virtual zero is the lowest-ranked vertex for which an ordering satisfying R3 to R5 exists. vz_idx gives its index (0, 1 or 2). For the vertices 100, 110, 210 at N_LEVELS=3 this gives vz_idx=1 and the sequence 110, 210, 211, 221.
- R7: When no vertex qualifies, seq_err is 1 and all four sequence words and vz_idx are 0. Otherwise seq_err is 0.
- R8: With in_parity=0 the outputs run seq0..seq3 from the second-last virtual-zero form to the last. With in_parity=1 the same four states come out in reverse order.
- R9: For a valid input at a rising clock edge, out_valid is 1 after that edge and the results are held in the output registers. After an edge without a valid input, out_valid is 0 and all other outputs keep their values.
- R10: While rst_n is low, every output is 0.
- R11: At N_LEVELS=5 the vertices 210, 310, 320 give vz_idx=0 and the sequence 321, 421, 431, 432. With in_parity=1 they give 432, 431, 421, 321.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The vertex words and parity are valid this cycle |
| in_parity | input | 1 | 0 = forward order, 1 = reversed order |
| vtx0 | input | 3*LW | Vertex 0 state word |
| vtx1 | input | 3*LW | Vertex 1 state word |
| vtx2 | input | 3*LW | Vertex 2 state word |
| out_valid | output | 1 | One-cycle pulse marking fresh results |
| seq0 | output | 3*LW | First state of the sequence |
| seq1 | output | 3*LW | Second state |
| seq2 | output | 3*LW | Third state |
| seq3 | output | 3*LW | Fourth state |
| vz_idx | output | 2 | Index of the vertex used as virtual zero |
| seq_err | output | 1 | No vertex admits a single-step ordering |

Internally each candidate vertex settles on one of ORD_JK, ORD_KJ or ORD_NONE. The output stage chooses EMIT_FWD, EMIT_REV or EMIT_FAULT, and that choice is loaded into the registers on a valid cycle.

## Verification
The hardest case to reach is a fall-through. Here the lowest-offset vertex has enough redundant forms but admits no single-step ordering, so the choice passes to the second- or third-ranked vertex. The fault path, where all three fail, is also hard to reach. Both arise only from particular triples that are not obvious from the ports. The bench therefore sweeps every ordered triple of three-level vertex words under both parities and compares each against an arithmetic model of the ranking and ordering rules. It also includes the named sector example, which falls through from vertex 0 to vertex 1.

// File: rtl/vzs_pkg.sv
package vzs_pkg;

    // Ordering chosen for the two middle vertices of one candidate
    typedef enum logic [1:0] {
        ORD_JK   = 2'd0,
        ORD_KJ   = 2'd1,
        ORD_NONE = 2'd2
    } ord_e;

    // Output emission mode
    typedef enum logic [1:0] {
        EMIT_FWD   = 2'd0,
        EMIT_REV   = 2'd1,
        EMIT_FAULT = 2'd2
    } emit_e;

    // Fixed-point weights of the offset cost (Q10)
    localparam int unsigned W_ALPHA_Q10 = 1024;
    localparam int unsigned W_BETA_Q10  = 1774;

endpackage

// File: rtl/vzs_offset_cost.sv
module vzs_offset_cost #(
    parameter int N_LEVELS = 3,
    localparam int LW = $clog2(N_LEVELS),
    localparam int SW = 3 * LW,
    localparam int CW = $clog2((N_LEVELS - 1) * 3822 + 1) + 1
) (
    input  logic [SW-1:0] state,
    output logic [CW-1:0] cost
);
    import vzs_pkg::*;

    int lv_a, lv_b, lv_c, d_alpha, d_beta;

    always_comb begin
        lv_a    = int'(state[SW-1 -: LW]);
        lv_b    = int'(state[2*LW-1 -: LW]);
        lv_c    = int'(state[LW-1:0]);
        d_alpha = 2 * lv_a - lv_b - lv_c;
        d_beta  = lv_b - lv_c;
        if (d_alpha < 0) d_alpha = -d_alpha;
        if (d_beta < 0)  d_beta  = -d_beta;
        cost = CW'(d_alpha * int'(W_ALPHA_Q10) + d_beta * int'(W_BETA_Q10));
    end

endmodule

// File: rtl/vzs_redund.sv
module vzs_redund #(
    parameter int N_LEVELS = 3,
    localparam int LW = $clog2(N_LEVELS),
    localparam int SW = 3 * LW
) (
    input  logic [SW-1:0] state,
    output logic [SW-1:0] last_st,
    output logic [SW-1:0] prev_st,
    output logic          multi
);
    int lv [3];
    int hi_lv, lo_lv, lift;

    always_comb begin
        for (int p = 0; p < 3; p++) lv[p] = int'(state[p*LW +: LW]);
        hi_lv = lv[0];
        lo_lv = lv[0];
        for (int p = 1; p < 3; p++) begin
            if (lv[p] > hi_lv) hi_lv = lv[p];
            if (lv[p] < lo_lv) lo_lv = lv[p];
        end
        lift  = (N_LEVELS - 1) - hi_lv;
        multi = (hi_lv - lo_lv) < (N_LEVELS - 1);
        for (int p = 0; p < 3; p++) begin
            last_st[p*LW +: LW] = LW'(lv[p] + lift);
            prev_st[p*LW +: LW] = multi ? LW'(lv[p] + lift - 1) : LW'(lv[p] + lift);
        end
    end

endmodule

// File: rtl/vzs_candidate.sv
module vzs_candidate #(
    parameter int N_LEVELS = 3,
    localparam int LW = $clog2(N_LEVELS),
    localparam int SW = 3 * LW
) (
    input  logic [SW-1:0] zero_lo,
    input  logic [SW-1:0] zero_hi,
    input  logic          zero_multi,
    input  logic [SW-1:0] side_j,
    input  logic [SW-1:0] side_k,
    output logic          fit,
    output logic [SW-1:0] mid_a,
    output logic [SW-1:0] mid_b
);
    import vzs_pkg::*;

    function automatic logic one_step(input logic [SW-1:0] x, input logic [SW-1:0] y);
        int n_diff;
        int d;
        logic wide;
        n_diff = 0;
        wide   = 1'b0;
        for (int p = 0; p < 3; p++) begin
            d = int'(x[p*LW +: LW]) - int'(y[p*LW +: LW]);
            if (d != 0) n_diff++;
            if (d > 1 || d < -1) wide = 1'b1;
        end
        return (n_diff == 1) && !wide;
    endfunction

    ord_e ord;

    always_comb begin
        if (!zero_multi)
            ord = ORD_NONE;
        else if (one_step(zero_lo, side_j) && one_step(side_j, side_k) && one_step(side_k, zero_hi))
            ord = ORD_JK;
        else if (one_step(zero_lo, side_k) && one_step(side_k, side_j) && one_step(side_j, zero_hi))
            ord = ORD_KJ;
        else
            ord = ORD_NONE;
    end

    always_comb begin
        unique case (ord)
            ORD_JK: begin
                fit   = 1'b1;
                mid_a = side_j;
                mid_b = side_k;
            end
            ORD_KJ: begin
                fit   = 1'b1;
                mid_a = side_k;
                mid_b = side_j;
            end
            default: begin
                fit   = 1'b0;
                mid_a = '0;
                mid_b = '0;
            end
        endcase
    end

endmodule

// File: rtl/vzs_seq_gen.sv
module vzs_seq_gen #(
    parameter int N_LEVELS = 3,
    localparam int LW = $clog2(N_LEVELS),
    localparam int SW = 3 * LW,
    localparam int CW = $clog2((N_LEVELS - 1) * 3822 + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_parity,
    input  logic [SW-1:0] vtx0,
    input  logic [SW-1:0] vtx1,
    input  logic [SW-1:0] vtx2,
    output logic          out_valid,
    output logic [SW-1:0] seq0,
    output logic [SW-1:0] seq1,
    output logic [SW-1:0] seq2,
    output logic [SW-1:0] seq3,
    output logic [1:0]    vz_idx,
    output logic          seq_err
);
    import vzs_pkg::*;

    logic [SW-1:0] vtx     [3];
    logic [CW-1:0] cost    [3];
    logic [SW-1:0] last_st [3];
    logic [SW-1:0] prev_st [3];
    logic          multi   [3];
    logic          fit     [3];
    logic [SW-1:0] mid_a   [3];
    logic [SW-1:0] mid_b   [3];
    logic [1:0]    rank    [3];

    assign vtx[0] = vtx0;
    assign vtx[1] = vtx1;
    assign vtx[2] = vtx2;

    for (genvar g = 0; g < 3; g++) begin : g_vertex
        vzs_offset_cost #(.N_LEVELS(N_LEVELS)) u_cost (
            .state (vtx[g]),
            .cost  (cost[g])
        );
        vzs_redund #(.N_LEVELS(N_LEVELS)) u_red (
            .state   (vtx[g]),
            .last_st (last_st[g]),
            .prev_st (prev_st[g]),
            .multi   (multi[g])
        );
    end

    for (genvar g = 0; g < 3; g++) begin : g_cand
        vzs_candidate #(.N_LEVELS(N_LEVELS)) u_cand (
            .zero_lo    (prev_st[g]),
            .zero_hi    (last_st[g]),
            .zero_multi (multi[g]),
            .side_j     (last_st[(g + 1) % 3]),
            .side_k     (last_st[(g + 2) % 3]),
            .fit        (fit[g]),
            .mid_a      (mid_a[g]),
            .mid_b      (mid_b[g])
        );
    end

    // Rank by offset cost; ties go to the lower index
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            rank[i] = 2'd0;
            for (int j = 0; j < 3; j++) begin
                if (j != i && ((cost[j] < cost[i]) || (cost[j] == cost[i] && j < i)))
                    rank[i] = rank[i] + 2'd1;
            end
        end
    end

    logic       found;
    logic [1:0] sel;

    always_comb begin
        found = 1'b0;
        sel   = 2'd0;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 3; i++) begin
                if (!found && rank[i] == 2'(r) && fit[i]) begin
                    found = 1'b1;
                    sel   = 2'(i);
                end
            end
        end
    end

    emit_e         emit;
    logic [SW-1:0] n_seq0, n_seq1, n_seq2, n_seq3;
    logic [1:0]    n_vz;
    logic          n_err;

    always_comb begin
        if (!found)
            emit = EMIT_FAULT;
        else if (in_parity)
            emit = EMIT_REV;
        else
            emit = EMIT_FWD;

        unique case (emit)
            EMIT_FWD: begin
                n_seq0 = prev_st[sel];
                n_seq1 = mid_a[sel];
                n_seq2 = mid_b[sel];
                n_seq3 = last_st[sel];
                n_vz   = sel;
                n_err  = 1'b0;
            end
            EMIT_REV: begin
                n_seq0 = last_st[sel];
                n_seq1 = mid_b[sel];
                n_seq2 = mid_a[sel];
                n_seq3 = prev_st[sel];
                n_vz   = sel;
                n_err  = 1'b0;
            end
            default: begin
                n_seq0 = '0;
                n_seq1 = '0;
                n_seq2 = '0;
                n_seq3 = '0;
                n_vz   = 2'd0;
                n_err  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            seq0      <= '0;
            seq1      <= '0;
            seq2      <= '0;
            seq3      <= '0;
            vz_idx    <= 2'd0;
            seq_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                seq0    <= n_seq0;
                seq1    <= n_seq1;
                seq2    <= n_seq2;
                seq3    <= n_seq3;
                vz_idx  <= n_vz;
                seq_err <= n_err;
            end
        end
    end

    // Checks on the registered outputs
    function automatic logic out_step(input logic [SW-1:0] x, input logic [SW-1:0] y);
        int n_diff;
        int d;
        logic wide;
        n_diff = 0;
        wide   = 1'b0;
        for (int p = 0; p < 3; p++) begin
            d = int'(x[p*LW +: LW]) - int'(y[p*LW +: LW]);
            if (d != 0) n_diff++;
            if (d > 1 || d < -1) wide = 1'b1;
        end
        return (n_diff == 1) && !wide;
    endfunction

    function automatic logic all_plus1(input logic [SW-1:0] x, input logic [SW-1:0] y);
        logic ok;
        ok = 1'b1;
        for (int p = 0; p < 3; p++)
            if (int'(y[p*LW +: LW]) != int'(x[p*LW +: LW]) + 1) ok = 1'b0;
        return ok;
    endfunction

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(seq0) && $stable(seq3) && $stable(vz_idx) && $stable(seq_err)));

    p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seq_err) |-> (out_step(seq0, seq1) && out_step(seq1, seq2) && out_step(seq2, seq3)));

    p_endpoint_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seq_err) |-> (all_plus1(seq0, seq3) || all_plus1(seq3, seq0)));

    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (seq0 == '0 && seq1 == '0 && seq2 == '0 && seq3 == '0 && vz_idx == 2'd0));

    p_vz_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vz_idx != 2'd3);

endmodule

// File: tb/vzs_seq_gen_bench.sv
module vzs_seq_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Three-level instance
    logic       iv3 = 1'b0, par3 = 1'b0;
    logic [5:0] a3 = '0, b3 = '0, c3 = '0;
    logic       ov3, er3;
    logic [5:0] s30, s31, s32, s33;
    logic [1:0] vz3;

    vzs_seq_gen #(.N_LEVELS(3)) u_vzs_seq_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(iv3), .in_parity(par3),
        .vtx0(a3), .vtx1(b3), .vtx2(c3),
        .out_valid(ov3), .seq0(s30), .seq1(s31), .seq2(s32), .seq3(s33),
        .vz_idx(vz3), .seq_err(er3)
    );

    // Five-level instance
    logic       iv5 = 1'b0, par5 = 1'b0;
    logic [8:0] a5 = '0, b5 = '0, c5 = '0;
    logic       ov5, er5;
    logic [8:0] s50, s51, s52, s53;
    logic [1:0] vz5;

    vzs_seq_gen #(.N_LEVELS(5)) u_vzs_seq_gen_n5 (
        .clk(clk), .rst_n(rst_n), .in_valid(iv5), .in_parity(par5),
        .vtx0(a5), .vtx1(b5), .vtx2(c5),
        .out_valid(ov5), .seq0(s50), .seq1(s51), .seq2(s52), .seq3(s53),
        .vz_idx(vz5), .seq_err(er5)
    );

    function automatic int pk(input int a, input int b, input int c, input int lw);
        return (a << (2 * lw)) | (b << lw) | c;
    endfunction

    function automatic bit step_ok(input int x[3], input int y[3]);
        int nd = 0;
        bit w = 0;
        for (int p = 0; p < 3; p++) begin
            int d = x[p] - y[p];
            if (d != 0) nd++;
            if (d > 1 || d < -1) w = 1;
        end
        return (nd == 1) && !w;
    endfunction

    // Arithmetic model of R1..R8; returns packed expected words
    function automatic void model(input int n, input int lw, input int v[3][3], input bit par,
                                  output int e[4], output int evz, output bit eerr);
        int cost[3], lst[3][3], prv[3][3], spread[3], order[3];
        bit used[3];
        bit hit = 0;
        for (int i = 0; i < 3; i++) begin
            int mx = v[i][0], mn = v[i][0];
            for (int p = 1; p < 3; p++) begin
                if (v[i][p] > mx) mx = v[i][p];
                if (v[i][p] < mn) mn = v[i][p];
            end
            spread[i] = mx - mn;
            for (int p = 0; p < 3; p++) begin
                lst[i][p] = v[i][p] + (n - 1 - mx);
                prv[i][p] = lst[i][p] - 1;
            end
            cost[i] = ((2*v[i][0]-v[i][1]-v[i][2]) < 0 ? -(2*v[i][0]-v[i][1]-v[i][2]) : (2*v[i][0]-v[i][1]-v[i][2])) * 1024
                    + ((v[i][1]-v[i][2]) < 0 ? (v[i][2]-v[i][1]) : (v[i][1]-v[i][2])) * 1774;
            used[i] = 0;
        end
        for (int r = 0; r < 3; r++) begin
            int best = -1;
            for (int i = 0; i < 3; i++)
                if (!used[i] && (best < 0 || cost[i] < cost[best])) best = i;
            used[best] = 1;
            order[r] = best;
        end
        for (int q = 0; q < 4; q++) e[q] = 0;
        evz = 0;
        eerr = 1;
        for (int r = 0; r < 3; r++) begin
            int i = order[r];
            int j = (i + 1) % 3;
            int k = (i + 2) % 3;
            int m1 = -1, m2 = -1;
            if (hit || spread[i] >= n - 1) continue;
            if (step_ok(prv[i], lst[j]) && step_ok(lst[j], lst[k]) && step_ok(lst[k], lst[i])) begin
                m1 = j; m2 = k;
            end else if (step_ok(prv[i], lst[k]) && step_ok(lst[k], lst[j]) && step_ok(lst[j], lst[i])) begin
                m1 = k; m2 = j;
            end
            if (m1 >= 0) begin
                int w[4];
                hit = 1;
                eerr = 0;
                evz = i;
                w[0] = pk(prv[i][0], prv[i][1], prv[i][2], lw);
                w[1] = pk(lst[m1][0], lst[m1][1], lst[m1][2], lw);
                w[2] = pk(lst[m2][0], lst[m2][1], lst[m2][2], lw);
                w[3] = pk(lst[i][0], lst[i][1], lst[i][2], lw);
                for (int q = 0; q < 4; q++) e[q] = par ? w[3 - q] : w[q];
            end
        end
    endfunction

    task automatic apply3(input int x, input int y, input int z, input bit par);
        @(negedge clk);
        a3 = 6'(x); b3 = 6'(y); c3 = 6'(z); par3 = par; iv3 = 1'b1;
        @(negedge clk);
        iv3 = 1'b0;
    endtask

    task automatic cmp3(input string tag, input int e[4], input int evz, input bit eerr);
        total++;
        if (!ov3 || int'(s30) != e[0] || int'(s31) != e[1] || int'(s32) != e[2] || int'(s33) != e[3]
            || int'(vz3) != evz || er3 != eerr) begin
            bad++;
            $display("FAIL %s act v=%0d %h %h %h %h vz=%0d err=%0d exp v=1 %h %h %h %h vz=%0d err=%0d",
                     tag, ov3, s30, s31, s32, s33, vz3, er3, e[0], e[1], e[2], e[3], evz, eerr);
        end
    endtask

    task automatic cmp5(input string tag, input int e[4], input int evz);
        total++;
        if (!ov5 || int'(s50) != e[0] || int'(s51) != e[1] || int'(s52) != e[2] || int'(s53) != e[3]
            || int'(vz5) != evz || er5) begin
            bad++;
            $display("FAIL %s act v=%0d %h %h %h %h vz=%0d err=%0d exp v=1 %h %h %h %h vz=%0d err=0",
                     tag, ov5, s50, s51, s52, s53, vz5, er5, e[0], e[1], e[2], e[3], evz);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int e[4];
        int evz;
        bit eerr;
        int v[3][3];

        // R10: reset state
        repeat (3) @(negedge clk);
        total++;
        if (ov3 || er3 || s30 != 0 || s31 != 0 || s32 != 0 || s33 != 0 || vz3 != 0 || ov5 || s50 != 0) begin
            bad++;
            $display("FAIL R10 act v=%0d err=%0d s0=%h exp all zero", ov3, er3, s30);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R6, R4: three-level sector, vertex 0 falls through to vertex 1
        apply3(pk(1,0,0,2), pk(1,1,0,2), pk(2,1,0,2), 1'b0);
        e = '{pk(1,1,0,2), pk(2,1,0,2), pk(2,1,1,2), pk(2,2,1,2)};
        cmp3("R6 sector fwd", e, 1, 1'b0);

        // R9: hold after an idle edge
        @(negedge clk);
        total++;
        if (ov3 || int'(s30) != e[0] || int'(s33) != e[3] || vz3 != 2'd1) begin
            bad++;
            $display("FAIL R9 hold act v=%0d s0=%h s3=%h vz=%0d exp v=0 %h %h vz=1", ov3, s30, s33, vz3, e[0], e[3]);
        end

        // R8: reversed order on odd parity
        apply3(pk(1,0,0,2), pk(1,1,0,2), pk(2,1,0,2), 1'b1);
        e = '{pk(2,2,1,2), pk(2,1,1,2), pk(2,1,0,2), pk(1,1,0,2)};
        cmp3("R8 sector rev", e, 1, 1'b0);

        // R7: no vertex with two redundant forms
        apply3(pk(2,0,0,2), pk(0,2,0,2), pk(0,0,2,2), 1'b0);
        e = '{0, 0, 0, 0};
        cmp3("R7 fault", e, 0, 1'b1);

        // R11: five-level case, both parities
        @(negedge clk);
        a5 = 9'(pk(2,1,0,3)); b5 = 9'(pk(3,1,0,3)); c5 = 9'(pk(3,2,0,3)); par5 = 1'b0; iv5 = 1'b1;
        @(negedge clk);
        iv5 = 1'b0;
        e = '{pk(3,2,1,3), pk(4,2,1,3), pk(4,3,1,3), pk(4,3,2,3)};
        cmp5("R11 fwd", e, 0);
        @(negedge clk);
        par5 = 1'b1; iv5 = 1'b1;
        @(negedge clk);
        iv5 = 1'b0;
        e = '{pk(4,3,2,3), pk(4,3,1,3), pk(4,2,1,3), pk(3,2,1,3)};
        cmp5("R11 rev", e, 0);

        // R1..R8: every ordered triple of three-level words, both parities
        for (int x = 0; x < 27; x++) begin
            for (int y = 0; y < 27; y++) begin
                for (int z = 0; z < 27; z++) begin
                    for (int p = 0; p < 2; p++) begin
                        int code[3];
                        code = '{x, y, z};
                        for (int i = 0; i < 3; i++) begin
                            v[i][0] = code[i] / 9;
                            v[i][1] = (code[i] / 3) % 3;
                            v[i][2] = code[i] % 3;
                        end
                        model(3, 2, v, p[0], e, evz, eerr);
                        apply3(pk(v[0][0],v[0][1],v[0][2],2), pk(v[1][0],v[1][1],v[1][2],2),
                               pk(v[2][0],v[2][1],v[2][2],2), p[0]);
                        cmp3("R1/R2/R3/R4/R5/R6/R7/R8 sweep", e, evz, eerr);
                    end
                end
            end
        end

        finish_run();
    end

endmodule